// File: doc/BRIEF.md
# LCD Controller Command Interpreter

This block sits behind the bit engine of a two-wire serial bus in a segment LCD controller. It sees each received byte as a strobe plus value, and it sees start and stop conditions as one-cycle indications. After a start, the first byte is compared against the device address. A matching address is acknowledged. Bytes after it are decoded as commands until one arrives with its top bit clear. From then on, every byte is forwarded as display data until the next stop or start.

Commands update the controller status:
- drive mode, bias and display enable;
- the banks used for writing and for display;
- the blink setting;
- the RAM pointer and the device subaddress.

The pointer and subaddress commands each produce a one-cycle load pulse, which the RAM sequencer consumes.

Command byte layout, with bit 7 as the continuation flag C:

| Bits 6..0 | Command | Fields |
|---|---|---|
| `0pppppp` | pointer load | p = RAM address |
| `10xEBMM` | mode set | E = enable; B = bias, 1 means 1/2 and 0 means 1/3; MM = drive |
| `110xsss` | subaddress select | s = subaddress |
| `1110xIO` | bank select | I = write bank; O = display bank |
| `1111AFF` | blink select | A = alternate-bank blink; FF = frequency, 00 = off |

Drive codes are: 01 static, 10 two backplanes, 11 three backplanes, 00 four backplanes.

Top module: `lcdc_cmd_top`

## Requirements
- R1: After reset the outputs are as follows.
  - Drive code is 00 (four backplanes) and bias is 0 (1/3).
  - Display enable is 0, blink frequency is 00 and alternate blink is 0.
  - Both banks are 0, and pointer and subaddress are 0.
  - All pulse outputs are low.
- R2: An address byte is acknowledged (`addr_ack_o` high for one cycle, in the cycle after its strobe) only when all three of these hold:
  - bits 7..2 equal `ADDR_HI`;
  - bit 1 equals `sa0`;
  - bit 0 is 0.
  Any other address makes the block ignore every byte until the next start.
- R3: A command byte with bit 7 = 1 is followed by another command. A command byte with bit 7 = 0 is followed by display data, and a data byte is never decoded as a command, even when its value looks like one. At most one pulse output is high in any cycle.
- R4: Mode set (bits 6..5 = 10) loads display enable from bit 3, bias from bit 2 and drive code from bits 1..0.
- R5: Pointer load (bit 6 = 0) pulses `ptr_load_o` for one cycle with `ptr_o` equal to bits 5..0.
- R6: Subaddress select (bits 6..4 = 110) pulses `sub_load_o` for one cycle with `sub_o` equal to bits 2..0.
- R7: Bank select (bits 6..3 = 1110) takes effect only in the following case:
  - the drive code in force is static (01) or two backplanes (10);
  - it then sets the write bank from bit 1 and the display bank from bit 0.
  In the three- and four-backplane modes the command is discarded and leaves both banks unchanged.
- R8: Blink select (bits 6..3 = 1111) stores the frequency from bits 1..0 and the alternate flag from bit 2. `blink_alt_o` shows the stored flag only while the drive code is static or two backplanes, and reads 0 otherwise.
- R9: A start puts the parser back to expecting an address, even in the middle of data. A byte strobed in the same cycle as a start is discarded.
- R10: Each data byte gives `data_vld_o` for one cycle, in the cycle after its strobe, with `data_o` equal to the byte.
- R11: After a stop, bytes have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Start or repeated start seen (one cycle) |
| bus_stop | input | 1 | Stop seen (one cycle) |
| byte_stb | input | 1 | Received byte valid (one cycle) |
| byte_val | input | 8 | Received byte |
| sa0 | input | 1 | Address select strap |
| mode_o | output | 2 | Drive code |
| bias_o | output | 1 | Bias select, 1 = 1/2 |
| disp_en_o | output | 1 | Display enable |
| in_bank_o | output | 1 | Bank for data writes |
| out_bank_o | output | 1 | Bank shown on the display |
| blink_freq_o | output | 2 | Blink frequency code |
| blink_alt_o | output | 1 | Alternate-bank blinking in force |
| ptr_load_o | output | 1 | Pointer load pulse |
| ptr_o | output | PTR_W | Pointer value |
| sub_load_o | output | 1 | Subaddress load pulse |
| sub_o | output | SUB_W | Subaddress value |
| data_vld_o | output | 1 | Display data valid pulse |
| data_o | output | 8 | Display data byte |
| addr_ack_o | output | 1 | Address acknowledged pulse |

## Verification
Four properties are checked on every cycle:
- that alternate blinking never shows in the three- and four-backplane modes;
- that a bank never changes outside the static and two-backplane modes;
- that pulses are mutually exclusive and never follow a start or stop;
- that forwarded data and acknowledges match the byte and strap seen one cycle earlier.

Whether a byte is read as a command or as data, and whether a non-matching address silences the rest of a transfer, depend on the byte history. Only the bench scenarios, which walk whole transfers, can show those.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  typedef enum logic [1:0] {
    DRV_MUX4   = 2'b00,
    DRV_STATIC = 2'b01,
    DRV_MUX2   = 2'b10,
    DRV_MUX3   = 2'b11
  } drive_t;

  typedef enum logic [2:0] {
    OP_PTR, OP_MODE, OP_SUB, OP_BANK, OP_BLINK
  } op_t;

  // leading-ones prefix decides the opcode
  function automatic op_t op_of(input logic [6:0] b);
    if (!b[6])      return OP_PTR;
    else if (!b[5]) return OP_MODE;
    else if (!b[4]) return OP_SUB;
    else if (!b[3]) return OP_BANK;
    else            return OP_BLINK;
  endfunction

  // bank switching exists only with one or two backplanes
  function automatic logic banks_usable(input drive_t m);
    return (m == DRV_STATIC) || (m == DRV_MUX2);
  endfunction

  function automatic logic addr_hit(input logic [7:0] b, input logic strap,
                                    input logic [5:0] hi);
    return (b[7:2] == hi) && (b[1] == strap) && !b[0];
  endfunction
endpackage

// File: rtl/lcdc_parse.sv
module lcdc_parse
  import lcdc_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b011100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       byte_stb,
  input  logic [7:0] byte_val,
  input  logic       sa0,
  output logic       cmd_stb,
  output logic       data_vld_o,
  output logic [7:0] data_o,
  output logic       addr_ack_o
);
  typedef enum logic [1:0] {PS_IDLE, PS_ADDR, PS_CMD, PS_DATA} pstate_t;
  pstate_t st;

  logic live_byte;
  assign live_byte = byte_stb && !bus_start && !bus_stop;
  assign cmd_stb   = live_byte && (st == PS_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= PS_IDLE;
      data_vld_o <= 1'b0;
      data_o     <= '0;
      addr_ack_o <= 1'b0;
    end else begin
      data_vld_o <= 1'b0;
      addr_ack_o <= 1'b0;
      if (bus_start) begin
        st <= PS_ADDR;
      end else if (bus_stop) begin
        st <= PS_IDLE;
      end else if (live_byte) begin
        case (st)
          PS_ADDR: begin
            if (addr_hit(byte_val, sa0, ADDR_HI)) begin
              addr_ack_o <= 1'b1;
              st         <= PS_CMD;
            end else begin
              st <= PS_IDLE;
            end
          end
          PS_CMD:  if (!byte_val[7]) st <= PS_DATA;
          PS_DATA: begin
            data_vld_o <= 1'b1;
            data_o     <= byte_val;
          end
          default: st <= PS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_pkg::*;
#(
  parameter int PTR_W = 6,
  parameter int SUB_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stb,
  input  logic [6:0]       cmd_byte,
  output drive_t           mode_q,
  output logic             bias_o,
  output logic             disp_en_o,
  output logic             in_bank_o,
  output logic             out_bank_o,
  output logic [1:0]       blink_freq_o,
  output logic             blink_alt_o,
  output logic             ptr_load_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             sub_load_o,
  output logic [SUB_W-1:0] sub_o
);
  op_t  op;
  logic alt_q;
  logic bank_ok;

  assign op          = op_of(cmd_byte);
  assign bank_ok     = banks_usable(mode_q);
  assign blink_alt_o = alt_q && bank_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= DRV_MUX4;
      bias_o       <= 1'b0;
      disp_en_o    <= 1'b0;
      in_bank_o    <= 1'b0;
      out_bank_o   <= 1'b0;
      blink_freq_o <= 2'b00;
      alt_q        <= 1'b0;
      ptr_load_o   <= 1'b0;
      ptr_o        <= '0;
      sub_load_o   <= 1'b0;
      sub_o        <= '0;
    end else begin
      ptr_load_o <= 1'b0;
      sub_load_o <= 1'b0;
      if (cmd_stb) begin
        case (op)
          OP_PTR: begin
            ptr_load_o <= 1'b1;
            ptr_o      <= cmd_byte[PTR_W-1:0];
          end
          OP_MODE: begin
            disp_en_o <= cmd_byte[3];
            bias_o    <= cmd_byte[2];
            mode_q    <= drive_t'(cmd_byte[1:0]);
          end
          OP_SUB: begin
            sub_load_o <= 1'b1;
            sub_o      <= cmd_byte[SUB_W-1:0];
          end
          OP_BANK: begin
            if (bank_ok) begin
              in_bank_o  <= cmd_byte[1];
              out_bank_o <= cmd_byte[0];
            end
          end
          default: begin
            alt_q        <= cmd_byte[2];
            blink_freq_o <= cmd_byte[1:0];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/lcdc_cmd_top.sv
module lcdc_cmd_top
  import lcdc_pkg::*;
#(
  parameter int         PTR_W   = 6,
  parameter int         SUB_W   = 3,
  parameter logic [5:0] ADDR_HI = 6'b011100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             byte_stb,
  input  logic [7:0]       byte_val,
  input  logic             sa0,
  output logic [1:0]       mode_o,
  output logic             bias_o,
  output logic             disp_en_o,
  output logic             in_bank_o,
  output logic             out_bank_o,
  output logic [1:0]       blink_freq_o,
  output logic             blink_alt_o,
  output logic             ptr_load_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             sub_load_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             data_vld_o,
  output logic [7:0]       data_o,
  output logic             addr_ack_o
);
  logic   cmd_stb;
  drive_t mode_q;

  assign mode_o = mode_q;

  lcdc_parse #(.ADDR_HI(ADDR_HI)) u_parse (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_stb(byte_stb), .byte_val(byte_val), .sa0(sa0),
    .cmd_stb(cmd_stb), .data_vld_o(data_vld_o), .data_o(data_o),
    .addr_ack_o(addr_ack_o)
  );

  lcdc_regs #(.PTR_W(PTR_W), .SUB_W(SUB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_byte(byte_val[6:0]),
    .mode_q(mode_q), .bias_o(bias_o), .disp_en_o(disp_en_o),
    .in_bank_o(in_bank_o), .out_bank_o(out_bank_o),
    .blink_freq_o(blink_freq_o), .blink_alt_o(blink_alt_o),
    .ptr_load_o(ptr_load_o), .ptr_o(ptr_o),
    .sub_load_o(sub_load_o), .sub_o(sub_o)
  );
endmodule

// File: rtl/lcdc_cmd_chk.sv
module lcdc_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_start,
  input logic       bus_stop,
  input logic       byte_stb,
  input logic [7:0] byte_val,
  input logic       sa0,
  input logic [1:0] mode_o,
  input logic       in_bank_o,
  input logic       out_bank_o,
  input logic       blink_alt_o,
  input logic       ptr_load_o,
  input logic       sub_load_o,
  input logic       data_vld_o,
  input logic [7:0] data_o,
  input logic       addr_ack_o
);
  p_ack_strap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack_o |-> ($past(byte_stb) && $past(byte_val[1]) == $past(sa0) && !$past(byte_val[0])));

  p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_vld_o, ptr_load_o, sub_load_o, addr_ack_o}));

  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bank_o != $past(in_bank_o) || out_bank_o != $past(out_bank_o))
      |-> ($past(mode_o) == 2'b01 || $past(mode_o) == 2'b10));

  p_alt_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blink_alt_o |-> (mode_o == 2'b01 || mode_o == 2'b10));

  p_start_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !(data_vld_o || ptr_load_o || sub_load_o || addr_ack_o));

  p_data_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld_o |-> ($past(byte_stb) && $past(byte_val) == data_o));

  p_stop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !(data_vld_o || ptr_load_o || sub_load_o || addr_ack_o));
endmodule

bind lcdc_cmd_top lcdc_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
  .byte_stb(byte_stb), .byte_val(byte_val), .sa0(sa0), .mode_o(mode_o),
  .in_bank_o(in_bank_o), .out_bank_o(out_bank_o), .blink_alt_o(blink_alt_o),
  .ptr_load_o(ptr_load_o), .sub_load_o(sub_load_o), .data_vld_o(data_vld_o),
  .data_o(data_o), .addr_ack_o(addr_ack_o)
);

// File: tb/tb_lcdc_cmd_top.sv
module tb_lcdc_cmd_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_start = 1'b0, bus_stop = 1'b0, byte_stb = 1'b0, sa0 = 1'b0;
  logic [7:0] byte_val = '0;
  logic [1:0] mode_o, blink_freq_o;
  logic       bias_o, disp_en_o, in_bank_o, out_bank_o, blink_alt_o;
  logic       ptr_load_o, sub_load_o, data_vld_o, addr_ack_o;
  logic [5:0] ptr_o;
  logic [2:0] sub_o;
  logic [7:0] data_o;
  int checks = 0, errors = 0;
  logic [3:0] pulses;  // {ack, ptr, sub, vld} seen after the last byte

  always #10 clk = ~clk;

  lcdc_cmd_top dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_stb = 1'b1; byte_val = b;
    @(negedge clk); byte_stb = 1'b0;
    pulses = {addr_ack_o, ptr_load_o, sub_load_o, data_vld_o};
  endtask

  task automatic do_start();
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 drive", mode_o, 2'b00);
    chk("R1 bias", bias_o, 0);
    chk("R1 enable", disp_en_o, 0);
    chk("R1 banks", {in_bank_o, out_bank_o}, 0);
    chk("R1 blink", {blink_freq_o, blink_alt_o}, 0);
    chk("R1 ptr/sub", {ptr_o, sub_o}, 0);
    chk("R1 pulses", {addr_ack_o, ptr_load_o, sub_load_o, data_vld_o}, 0);
  endtask

  task automatic t_mode_data();
    do_start();
    send(8'h70); chk("R2 ack", pulses, 4'b1000);
    send(8'hC9);
    chk("R4 mode fields", {mode_o, bias_o, disp_en_o}, {2'b01, 1'b0, 1'b1});
    send(8'h2A); chk("R5 ptr pulse", pulses, 4'b0100); chk("R5 ptr", ptr_o, 6'd42);
    send(8'h5A); chk("R10 vld", pulses, 4'b0001); chk("R10 data", data_o, 8'h5A);
    send(8'hC7); chk("R3 data not cmd", data_o, 8'hC7);
    chk("R3 mode untouched", {mode_o, disp_en_o}, {2'b01, 1'b1});
    do_stop();
  endtask

  task automatic t_sub_bank_blink();
    do_start();
    send(8'h70);
    send(8'hE5); chk("R6 sub pulse", pulses, 4'b0010); chk("R6 sub", sub_o, 3'd5);
    send(8'hF3); chk("R7 bank static", {in_bank_o, out_bank_o}, 2'b11);
    send(8'hFE); chk("R8 blink static", {blink_freq_o, blink_alt_o}, {2'b10, 1'b1});
    send(8'hC7); chk("R4 mux3", {mode_o, bias_o, disp_en_o}, {2'b11, 1'b1, 1'b0});
    chk("R8 alt masked mux3", blink_alt_o, 0);
    chk("R8 freq kept", blink_freq_o, 2'b10);
    send(8'hF0); chk("R7 bank ignored", {in_bank_o, out_bank_o}, 2'b11);
    send(8'h4A); chk("R4 mux2", mode_o, 2'b10);
    chk("R8 alt back", blink_alt_o, 1);
    chk("R7 still ignored", {in_bank_o, out_bank_o}, 2'b11);
    send(8'hF0); chk("R3 data after C0", pulses, 4'b0001);
    chk("R3 bank not hit by data", {in_bank_o, out_bank_o}, 2'b11);
    do_stop();
  endtask

  task automatic t_bad_addr();
    do_start();
    send(8'h72); chk("R2 strap mismatch", pulses, 0);
    send(8'hC9); chk("R2 silent mode", mode_o, 2'b10);
    send(8'h00); chk("R2 silent ptr", pulses, 0);
    do_start();
    send(8'h71); chk("R2 read bit", pulses, 0);
    sa0 = 1'b1;
    do_start();
    send(8'h70); chk("R2 strap1 reject", pulses, 0);
    do_start();
    send(8'h72); chk("R2 strap1 ack", pulses, 4'b1000);
    sa0 = 1'b0;
    do_stop();
  endtask

  task automatic t_restart_stop();
    do_start();
    send(8'h70);
    send(8'h05); chk("R5 ptr 5", ptr_o, 6'd5);
    send(8'h11); chk("R10 data 11", data_o, 8'h11);
    do_start();
    send(8'h70); chk("R9 restart ack", pulses, 4'b1000);
    send(8'h0C); chk("R9 cmd after restart", pulses, 4'b0100);
    chk("R9 ptr 12", ptr_o, 6'd12);
    @(negedge clk); bus_start = 1'b1; byte_stb = 1'b1; byte_val = 8'h70;
    @(negedge clk); bus_start = 1'b0; byte_stb = 1'b0;
    chk("R9 byte with start", {addr_ack_o, data_vld_o}, 0);
    send(8'h70); chk("R9 ack after", pulses, 4'b1000);
    send(8'h33); chk("R9 ptr 33", ptr_o, 6'h33);
    do_stop();
    send(8'h81); chk("R11 after stop", pulses, 0);
    send(8'h22); chk("R11 no data", pulses, 0);
    chk("R11 ptr kept", ptr_o, 6'h33);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_mode_data();
    t_sub_bank_blink();
    t_bad_addr();
    t_restart_stop();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule